// File: doc/BRIEF.md
# Block-Cipher Accelerator Register Front End

This block is the register-level front end of a block-cipher engine on a 32-bit memory-mapped bus. Software uses it to program a control word, load up to four key pairs and two IV pairs, and stream words in and out through two small word FIFOs. The block also runs the control sequences that the engine needs: turning it on and off, showing when it is busy, emptying both FIFOs, and running a key-preparation pass that ends by itself. Eight read-only identification bytes let software recognise the block.

The cipher datapath is not part of this block. A placeholder core with a fixed latency takes its place. It pulls one word from the input FIFO, holds busy for a set number of cycles, and pushes the word XORed with the first key pair into the output FIFO. If the output FIFO is full, it waits. This lets the control and flow behaviour be checked with no real cipher. Only word-aligned accesses have any effect. Reads are combinational. A read of the data-out word removes that word from the output FIFO.

Top module: `cfe_ctrl_top`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x0482 and the status word (offset 0x04) reads 0x03.
- R2: Control bits 0 to 10, 12, 13 and 15 read back as written. Bit 14 (flush) always reads 0. Bit 11 reads 1 only while key preparation runs, so writing it without bit 15 has no effect.
- R3: Status bit 0 is input FIFO empty, bit 1 is input not full, bit 2 is output not empty, bit 3 is output full and bit 4 is busy. With bit 15 set, a word written at 0x08 comes back at 0x10 as word ^ key(0x28) ^ key(0x2C).
- R4: While the placeholder core works on a word, status bit 4 reads 1.
- R5: A write to 0x08 while the input FIFO is full is dropped and leaves the FIFO contents unchanged.
- R6: When the output FIFO is full, the core holds its result with busy high (status 0x1E when one more word waits). Results then come out in input order once space frees.
- R7: Writes to the key words (0x28 to 0x44) or IV words (0x48 to 0x54) while busy is high are ignored.
- R8: Key words read 0 while control bit 10 is clear. IV words stay readable.
- R9: A control write with bits 11 and 15 set, made while not busy, starts key preparation. Busy stays high for KPREP_CYCLES cycles, and then bit 15 and busy clear on their own.
- R10: A control write with bit 14 set empties both FIFOs, so that status reads 0x03, but only when the engine is disabled and idle. Otherwise the flush is ignored.
- R11: Offsets 0xFE0 to 0xFFC return the bytes E3, 05, 28, 00, 0D, F0, 05, B1 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |

## Verification
The data path is tried with one word at a time, with a burst larger than the input FIFO while the engine is off, and with a burst larger than the output FIFO while the engine runs. The first case checks the transform and the busy window. The second tells a dropped word apart from one that is merely queued. The third tells a stalled core apart from a lost result, because the outputs must keep their order. Key preparation, flush attempts made while the engine is enabled and while it is disabled, and key writes made during busy are each followed by read-backs. These read-backs show whether the state changed.

// File: rtl/cfe_pkg.sv
// Shared constants for the cipher front end: word indices of the register
// map, control bit positions, reset value and the identification bytes.
package cfe_pkg;
    localparam int CR_KPREP   = 11;
    localparam int CR_FLUSH   = 14;
    localparam int CR_ENABLE  = 15;
    localparam logic [15:0] CR_RESET  = 16'h0482;
    localparam logic [15:0] CR_STORED = 16'hB7FF;

    localparam int W_CTRL = 0;
    localparam int W_STAT = 1;
    localparam int W_DIN  = 2;
    localparam int W_DOUT = 4;
    localparam int W_KEY0 = 10;
    localparam int W_IV0  = 18;
    localparam int NUM_KEY_WORDS = 8;
    localparam int NUM_IV_WORDS  = 4;

    typedef enum logic {CORE_IDLE, CORE_WORK} core_state_t;

    // Identification byte for slot 0..7 of the top ID window
    function automatic logic [7:0] id_byte(input logic [2:0] slot);
        case (slot)
            3'd0: id_byte = 8'hE3;
            3'd1: id_byte = 8'h05;
            3'd2: id_byte = 8'h28;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/cfe_word_fifo.sv
// Word FIFO with synchronous flush.
// Assumes DEPTH is a power of two, 2 or more. A push when full and a pop when
// empty are both ignored. The head word is visible without a read latency.
module cfe_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/cfe_stub_core.sv
// Placeholder for the cipher datapath.
// When run_ok is high and a word is waiting, it takes one word and works for
// LAT cycles. It then presents word ^ key_mix and pushes it once the output
// FIFO has room. Busy covers the whole span, stall included. LAT >= 1.
module cfe_stub_core
    import cfe_pkg::*;
#(
    parameter int W   = 32,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_ok,
    input  logic [W-1:0] key_mix,
    input  logic         in_empty,
    input  logic [W-1:0] in_word,
    output logic         in_pop,
    input  logic         out_full,
    output logic         out_push,
    output logic [W-1:0] out_word,
    output logic         busy
);
    localparam int CW = $clog2(LAT+1);

    core_state_t  state;
    logic [CW-1:0] cnt;
    logic [W-1:0]  result_q;

    assign in_pop   = (state == CORE_IDLE) && run_ok && !in_empty;
    assign out_push = (state == CORE_WORK) && (cnt == '0) && !out_full;
    assign out_word = result_q;
    assign busy     = (state == CORE_WORK);

    // Take a word, count the latency, then hand the result over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CORE_IDLE;
            cnt      <= '0;
            result_q <= '0;
        end else begin
            case (state)
                CORE_IDLE: if (in_pop) begin
                    state    <= CORE_WORK;
                    cnt      <= CW'(LAT-1);
                    result_q <= in_word ^ key_mix;
                end
                default: begin
                    if (cnt != '0)     cnt <= cnt - 1'b1;
                    else if (!out_full) state <= CORE_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/cfe_ctrl_top.sv
// Register front end of a block-cipher accelerator.
// It decodes word-aligned accesses and holds the control word, the key words
// and the IV words. It runs key preparation and flush, and joins the two word
// FIFOs to the placeholder core. Assumes one-cycle accesses; reads have no
// wait states.
module cfe_ctrl_top
    import cfe_pkg::*;
#(
    parameter int FIFO_DEPTH   = 4,
    parameter int CORE_LAT     = 4,
    parameter int KPREP_CYCLES = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);
    localparam int KP_W  = $clog2(KPREP_CYCLES+1);

    logic [9:0]  widx;
    logic        acc_wr, acc_rd;
    logic        ctrl_we, kprep_go, kprep_run, kprep_done, flush_go, busy;
    logic [15:0] ctrl_q;
    logic [KP_W-1:0] kprep_cnt;
    logic [31:0] key_q [NUM_KEY_WORDS];
    logic [31:0] iv_q  [NUM_IV_WORDS];
    logic        in_key, in_iv;
    logic [2:0]  key_sel;
    logic [1:0]  iv_sel;
    logic [31:0] status_w;

    logic              in_pop, in_empty, in_full;
    logic [31:0]       in_head;
    logic [CNT_W-1:0]  in_count;
    logic              out_push, out_empty, out_full, core_busy;
    logic [31:0]       out_head, core_word;
    logic [CNT_W-1:0]  out_count;

    assign widx     = bus_addr[11:2];
    assign acc_wr   = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
    assign acc_rd   = bus_sel && !bus_wr && (bus_addr[1:0] == 2'b00);
    assign ctrl_we  = acc_wr && (widx == 10'(W_CTRL));
    assign busy     = core_busy || kprep_run;
    assign kprep_go = ctrl_we && bus_wdata[CR_KPREP] && bus_wdata[CR_ENABLE] && !busy;
    assign flush_go = ctrl_we && bus_wdata[CR_FLUSH] && !ctrl_q[CR_ENABLE] && !busy;
    assign kprep_done = kprep_run && (kprep_cnt == '0);

    assign in_key  = (widx >= 10'(W_KEY0)) && (widx < 10'(W_KEY0 + NUM_KEY_WORDS));
    assign in_iv   = (widx >= 10'(W_IV0))  && (widx < 10'(W_IV0 + NUM_IV_WORDS));
    assign key_sel = 3'(widx - 10'(W_KEY0));
    assign iv_sel  = 2'(widx - 10'(W_IV0));

    assign status_w = {27'd0, busy, out_full, !out_empty, !in_full, in_empty};

    // Control word: stored fields, with enable dropped when preparation ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CR_RESET;
        end else begin
            if (ctrl_we)    ctrl_q <= bus_wdata[15:0] & CR_STORED;
            if (kprep_done) ctrl_q[CR_ENABLE] <= 1'b0;
        end
    end

    // Key preparation timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kprep_run <= 1'b0;
            kprep_cnt <= '0;
        end else if (kprep_go) begin
            kprep_run <= 1'b1;
            kprep_cnt <= KP_W'(KPREP_CYCLES-1);
        end else if (kprep_run) begin
            if (kprep_done) kprep_run <= 1'b0;
            else            kprep_cnt <= kprep_cnt - 1'b1;
        end
    end

    // Key and IV words, written only while idle
    for (genvar g = 0; g < NUM_KEY_WORDS; g++) begin : g_key
        always_ff @(posedge clk) begin
            if (!rst_n) key_q[g] <= '0;
            else if (acc_wr && !busy && widx == 10'(W_KEY0 + g)) key_q[g] <= bus_wdata;
        end
    end
    for (genvar g = 0; g < NUM_IV_WORDS; g++) begin : g_iv
        always_ff @(posedge clk) begin
            if (!rst_n) iv_q[g] <= '0;
            else if (acc_wr && !busy && widx == 10'(W_IV0 + g)) iv_q[g] <= bus_wdata;
        end
    end

    // Read data selection
    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            if (widx == 10'(W_CTRL))      bus_rdata = {16'd0, ctrl_q | (16'(kprep_run) << CR_KPREP)};
            else if (widx == 10'(W_STAT)) bus_rdata = status_w;
            else if (widx == 10'(W_DOUT)) bus_rdata = out_empty ? '0 : out_head;
            else if (in_key)              bus_rdata = ctrl_q[10] ? key_q[key_sel] : '0;
            else if (in_iv)               bus_rdata = iv_q[iv_sel];
            else if (bus_addr[11:5] == 7'h7F) bus_rdata = {24'd0, id_byte(bus_addr[4:2])};
        end
    end

    cfe_word_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_in_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush_go),
        .push(acc_wr && widx == 10'(W_DIN)), .wdata(bus_wdata),
        .pop(in_pop), .rdata(in_head), .count(in_count),
        .empty(in_empty), .full(in_full)
    );

    cfe_stub_core #(.W(32), .LAT(CORE_LAT)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run_ok(ctrl_q[CR_ENABLE] && !kprep_run && !kprep_go),
        .key_mix(key_q[0] ^ key_q[1]),
        .in_empty(in_empty), .in_word(in_head), .in_pop(in_pop),
        .out_full(out_full), .out_push(out_push), .out_word(core_word),
        .busy(core_busy)
    );

    cfe_word_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_out_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush_go),
        .push(out_push), .wdata(core_word),
        .pop(acc_rd && widx == 10'(W_DOUT)), .rdata(out_head), .count(out_count),
        .empty(out_empty), .full(out_full)
    );
endmodule

// File: rtl/cfe_ctrl_checker.sv
// Temporal checks on the cipher front end, attached through bind.
// Assumes the same bus timing as the top: one-cycle accesses.
module cfe_ctrl_checker #(
    parameter int FIFO_DEPTH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] status,
    input logic        enable,
    input logic        kprep_run,
    input logic        in_pop,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] in_count,
    input logic [31:0] key_first
);
    logic ctrl_wr, din_wr, key_wr;
    assign ctrl_wr = bus_sel && bus_wr && bus_addr == 12'h000;
    assign din_wr  = bus_sel && bus_wr && bus_addr == 12'h008;
    assign key_wr  = bus_sel && bus_wr && bus_addr == 12'h028;

    // R10: an accepted flush leaves the status word at 0x03
    assert_flush_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[14] && !bus_wdata[11] && !enable && !status[4]) |=> (status == 32'h3));

    // R7: the first key word holds while busy
    assert_key_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && status[4]) |=> $stable(key_first));

    // R9: the end of key preparation leaves the engine disabled
    assert_kprep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kprep_run) |-> !enable);

    // R5: a word written into a full input FIFO does not change it
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (din_wr && !status[1] && !in_pop) |=> (in_count == $past(in_count)));

    // R3: a full output FIFO is never reported empty
    assert_out_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |-> status[2]);
endmodule

bind cfe_ctrl_top cfe_ctrl_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status_w),
    .enable(ctrl_q[15]), .kprep_run(kprep_run), .in_pop(in_pop),
    .in_count(in_count), .key_first(key_q[0])
);

// File: tb/cfe_ctrl_top_test.sv
// Directed bench: one task per scenario, each checking its own results.
module cfe_ctrl_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int total = 0, bad = 0;

    localparam logic [31:0] K0 = 32'h0F0F1234, K1 = 32'hF000ABCD;
    localparam logic [31:0] MIX = K0 ^ K1;

    cfe_ctrl_top #(.FIFO_DEPTH(4), .CORE_LAT(4), .KPREP_CYCLES(10)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset;
        expect_rd("R1 control reset", 12'h000, 32'h0482);
        expect_rd("R1 status reset", 12'h004, 32'h3);
    endtask

    task automatic t_fields;
        wr(12'h000, 32'h77FF);
        expect_rd("R2 stored fields, flush reads 0", 12'h000, 32'h37FF);
        wr(12'h000, 32'h0C82);
        expect_rd("R2 prep bit without enable", 12'h000, 32'h0482);
        expect_rd("R2 no busy", 12'h004, 32'h3);
    endtask

    task automatic t_key_gate;
        wr(12'h028, 32'h11112222);
        wr(12'h048, 32'hA5A5C3C3);
        wr(12'h000, 32'h0082);
        expect_rd("R8 key hidden", 12'h028, 32'h0);
        expect_rd("R8 iv visible", 12'h048, 32'hA5A5C3C3);
        wr(12'h000, 32'h0482);
        expect_rd("R8 key visible", 12'h028, 32'h11112222);
        wr(12'h028, K0);
        wr(12'h02C, K1);
    endtask

    task automatic t_transform;
        logic [31:0] v;
        wr(12'h000, 32'h8482);
        wr(12'h008, 32'h12345678);
        idle(1);
        rd(12'h004, v);
        check("R4 busy while working", {31'd0, v[4]}, 32'h1);
        idle(10);
        expect_rd("R3 status with result", 12'h004, 32'h07);
        expect_rd("R3 transform", 12'h010, 32'h12345678 ^ MIX);
        expect_rd("R3 status drained", 12'h004, 32'h03);
    endtask

    task automatic t_overflow;
        wr(12'h000, 32'h0482);
        for (int i = 0; i < 5; i++) wr(12'h008, 32'hA0000000 + i);
        expect_rd("R5 input full", 12'h004, 32'h00);
        wr(12'h000, 32'h8482);
        idle(40);
        expect_rd("R5 output full", 12'h004, 32'h0F);
        for (int i = 0; i < 4; i++) expect_rd("R5 kept word", 12'h010, (32'hA0000000 + i) ^ MIX);
        expect_rd("R5 extra word dropped", 12'h004, 32'h03);
    endtask

    task automatic t_stall;
        for (int i = 0; i < 6; i++) wr(12'h008, 32'hB0000000 + i);
        idle(40);
        expect_rd("R6 stall status", 12'h004, 32'h1E);
        for (int i = 0; i < 4; i++) expect_rd("R6 order", 12'h010, (32'hB0000000 + i) ^ MIX);
        idle(15);
        for (int i = 4; i < 6; i++) expect_rd("R6 order after stall", 12'h010, (32'hB0000000 + i) ^ MIX);
        expect_rd("R6 drained", 12'h004, 32'h03);
    endtask

    task automatic t_kprep;
        wr(12'h000, 32'h8C82);
        expect_rd("R9 prep running", 12'h000, 32'h8C82);
        expect_rd("R9 busy", 12'h004, 32'h13);
        wr(12'h028, 32'hDEADBEEF);
        wr(12'h048, 32'h01020304);
        idle(15);
        expect_rd("R9 enable cleared", 12'h000, 32'h0482);
        expect_rd("R9 busy cleared", 12'h004, 32'h03);
        expect_rd("R7 key unchanged", 12'h028, K0);
        expect_rd("R7 iv unchanged", 12'h048, 32'hA5A5C3C3);
    endtask

    task automatic t_flush;
        wr(12'h000, 32'h8482);
        wr(12'h008, 32'h55AA55AA);
        idle(10);
        wr(12'h000, 32'hC482);
        expect_rd("R10 flush ignored when enabled", 12'h004, 32'h07);
        wr(12'h000, 32'h0482);
        wr(12'h008, 32'h1);
        wr(12'h008, 32'h2);
        expect_rd("R10 before flush", 12'h004, 32'h06);
        wr(12'h000, 32'h4482);
        expect_rd("R10 after flush", 12'h004, 32'h03);
        expect_rd("R10 out empty reads 0", 12'h010, 32'h0);
    endtask

    task automatic t_ids;
        logic [7:0] exp_id [8] = '{8'hE3, 8'h05, 8'h28, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) expect_rd("R11 id byte", 12'hFE0 + 12'(4*i), {24'd0, exp_id[i]});
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_fields;
        t_key_gate;
        t_transform;
        t_overflow;
        t_stall;
        t_kprep;
        t_flush;
        t_ids;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=%h exp=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule